// File: doc/BRIEF.md
# Reflected CRC-16 Serial Engine

This block computes the 16-bit check word carried at the end of binary serial frames. The register starts at all ones. Each frame byte enters through a valid/ready handshake and is XORed into the low eight register bits. The register then takes eight single-bit right shifts, one per clock. On every shift whose outgoing bit was a one, the register is XORed with the reflected polynomial A001h. A clear input restarts the frame at any time, including in the middle of a byte.

When the last byte has been processed, an end-of-frame request streams the two check bytes out on a byte output with its own valid/ready pair, low-order byte first. To check a received frame, the user feeds the frame and then its two received check bytes (low first) as ordinary data and issues a check request. A register value of zero raises the pass flag; any other value raises the error flag.

Top module: `crc16r_engine`

## Requirements
- R1: After reset, or one clock edge after `clr` is sampled high, `crc_out` is FFFFh, `crc_ok` and `crc_err` are low and no output byte is valid. `in_ready` is high while idle and `clr` is low.
- R2: For an accepted byte B, the register is first XORed with B in bits 7..0. It then takes eight right shifts with a zero entering bit 15. Each shift whose pre-shift bit 0 was 1 is followed by an XOR with A001h. `crc_out` shows the value after every shift.
- R3: Once a byte is accepted, `in_ready` stays low for exactly eight cycles, and no byte offered during that time is taken.
- R4: For the frame 01h 03h 21h 02h 00h 02h, starting from FFFFh, `crc_out` ends at F76Fh.
- R5: A pulse on `eof_req` while idle raises `out_valid` on the next cycle. `out_data` first carries `crc_out[7:0]` and then `crc_out[15:8]`, each held until accepted by `out_ready`. The register does not change during the emission.
- R6: A pulse on `chk_req` while idle sets `crc_ok` on the next cycle when the register is zero, and sets `crc_err` otherwise. The flag stays set until a clear or the next accepted byte. The two flags are never high together.
- R7: A `clr` during shifting or emission abandons the operation. `crc_out` is FFFFh one edge later, and `in_ready` is high once `clr` falls.
- R8: In the idle state, a valid input byte takes priority over `eof_req`, and `eof_req` takes priority over `chk_req`. A request that loses is dropped.
- R9: `in_ready` is low for as long as `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Start a new frame; register back to FFFFh |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine idle and able to take a byte |
| eof_req | input | 1 | Request emission of the check bytes |
| chk_req | input | 1 | Request a zero test of the register |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output check byte, low byte first |
| out_ready | input | 1 | Output byte consumed |
| crc_out | output | 16 | Current register contents |
| crc_ok | output | 1 | Check passed (register was zero) |
| crc_err | output | 1 | Check failed (register non-zero) |

## Verification
A byte accepted at one rising edge finishes its eighth shift eight edges later, and `in_ready` returns in the same cycle. A clear takes effect one edge after it is sampled. The check flags and the first output byte appear one edge after their request. The bench drives inputs 2 ns after each rising edge and samples outputs at the falling edge. At every falling edge, a reference model advanced on the same rising edges is compared against the design's outputs. Directed checks count the low-ready window and sample the final register, the emitted bytes and the flags only at the falling edge that follows the due edge.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EMIT  = 2'd2
    } state_e;

    localparam int DEF_CRC_W  = 16;
    localparam int DEF_BYTE_W = 8;
endpackage

// File: rtl/crc16r_step.sv
module crc16r_step #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     POLY = 16'hA001
) (
    input  logic [W-1:0] crc_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] shifted;

    // one right shift, zero into the top bit, conditional polynomial fold
    assign shifted = {1'b0, crc_i[W-1:1]};
    assign crc_o   = crc_i[0] ? (shifted ^ POLY) : shifted;
endmodule

// File: rtl/crc16r_mixin.sv
module crc16r_mixin #(
    parameter int CRC_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CRC_W-1:0]  crc_o
);
    for (genvar g = 0; g < CRC_W; g++) begin : g_bit
        if (g < BYTE_W) begin : g_mix
            assign crc_o[g] = crc_i[g] ^ byte_i[g];
        end else begin : g_pass
            assign crc_o[g] = crc_i[g];
        end
    end
endmodule

// File: rtl/crc16r_bytesel.sv
module crc16r_bytesel #(
    parameter int CRC_W  = 16,
    parameter int BYTE_W = 8,
    parameter int NBYTES = CRC_W / BYTE_W,
    parameter int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lanes [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lanes[g] = crc_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[idx_i];
endmodule

// File: rtl/crc16r_engine.sv
module crc16r_engine #(
    parameter int                 CRC_W  = crc16r_pkg::DEF_CRC_W,
    parameter int                 BYTE_W = crc16r_pkg::DEF_BYTE_W,
    parameter logic [CRC_W-1:0]   POLY   = 16'hA001,
    parameter logic [CRC_W-1:0]   INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              eof_req,
    input  logic              chk_req,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_ok,
    output logic              crc_err
);
    import crc16r_pkg::*;

    localparam int NBYTES = CRC_W / BYTE_W;
    localparam int CNT_W  = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE  = IDX_W'(NBYTES - 1);

    typedef struct packed {
        state_e             st;
        logic [CRC_W-1:0]   crc;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   idx;
        logic               ok;
        logic               err;
    } regs_t;

    regs_t r_q, r_d;

    logic [CRC_W-1:0]  mixed;
    logic [CRC_W-1:0]  stepped;
    logic [BYTE_W-1:0] sel_byte;

    crc16r_mixin #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_mixin (
        .crc_i  (r_q.crc),
        .byte_i (in_data),
        .crc_o  (mixed)
    );

    crc16r_step #(.W(CRC_W), .POLY(POLY)) u_step (
        .crc_i (r_q.crc),
        .crc_o (stepped)
    );

    crc16r_bytesel #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES), .IDX_W(IDX_W)) u_sel (
        .crc_i  (r_q.crc),
        .idx_i  (r_q.idx),
        .byte_o (sel_byte)
    );

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.st  = ST_IDLE;
            r_d.crc = INIT;
            r_d.cnt = '0;
            r_d.idx = '0;
            r_d.ok  = 1'b0;
            r_d.err = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (in_valid) begin
                        r_d.crc = mixed;
                        r_d.cnt = '0;
                        r_d.st  = ST_SHIFT;
                        r_d.ok  = 1'b0;
                        r_d.err = 1'b0;
                    end else if (eof_req) begin
                        r_d.idx = '0;
                        r_d.st  = ST_EMIT;
                    end else if (chk_req) begin
                        r_d.ok  = (r_q.crc == '0);
                        r_d.err = (r_q.crc != '0);
                    end
                end
                ST_SHIFT: begin
                    r_d.crc = stepped;
                    if (r_q.cnt == LAST_SHIFT) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (r_q.idx == LAST_BYTE) begin
                            r_d.idx = '0;
                            r_d.st  = ST_IDLE;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.crc <= INIT;
            r_q.cnt <= '0;
            r_q.idx <= '0;
            r_q.ok  <= 1'b0;
            r_q.err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_IDLE) && !clr;
    assign out_valid = (r_q.st == ST_EMIT);
    assign out_data  = sel_byte;
    assign crc_out   = r_q.crc;
    assign crc_ok    = r_q.ok;
    assign crc_err   = r_q.err;
endmodule

// File: rtl/crc16r_engine_chk.sv
module crc16r_engine_chk #(
    parameter int               CRC_W  = 16,
    parameter int               BYTE_W = 8,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_ready,
    input logic [CRC_W-1:0]  crc_out,
    input logic              crc_ok,
    input logic              crc_err
);
    logic       trk;
    logic [7:0] low_cnt;

    // measures the low-ready window that follows each accepted byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk     <= 1'b0;
            low_cnt <= '0;
        end else if (clr) begin
            trk     <= 1'b0;
            low_cnt <= '0;
        end else if (in_valid && in_ready) begin
            trk     <= 1'b1;
            low_cnt <= '0;
        end else if (trk && !in_ready) begin
            low_cnt <= low_cnt + 8'd1;
        end else if (trk) begin
            trk <= 1'b0;
        end
    end

    p_clear_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == INIT) && !crc_ok && !crc_err && !out_valid);

    p_ready_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trk && in_ready) |-> (low_cnt == 8'(BYTE_W)));

    p_low_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == crc_out[BYTE_W-1:0]));

    p_hold_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    p_emit_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !clr) |=> $stable(crc_out));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(crc_out));

    p_busy_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

bind crc16r_engine crc16r_engine_chk #(
    .CRC_W(CRC_W), .BYTE_W(BYTE_W), .INIT(INIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .crc_out   (crc_out),
    .crc_ok    (crc_ok),
    .crc_err   (crc_err)
);

// File: tb/crc16r_engine_tb.sv
module crc16r_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        eof_req = 1'b0;
    logic        chk_req = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic [15:0] crc_out;
    logic        crc_ok;
    logic        crc_err;

    int checks = 0;
    int fails  = 0;
    bit stall  = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    crc16r_engine u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .eof_req(eof_req), .chk_req(chk_req),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .crc_out(crc_out), .crc_ok(crc_ok), .crc_err(crc_err)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_st = 0;      // 0 idle, 1 shifting, 2 emitting
    int       m_left = 0;
    int       m_idx = 0;
    bit [15:0] m_crc = 16'hFFFF;
    bit       m_ok = 0, m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_crc = 16'hFFFF; m_ok = 0; m_err = 0; m_idx = 0;
        end else if (clr) begin
            m_st = 0; m_crc = 16'hFFFF; m_ok = 0; m_err = 0; m_idx = 0;
        end else if (m_st == 0) begin
            if (in_valid) begin
                m_crc = m_crc ^ {8'h00, in_data};
                m_left = 8; m_st = 1; m_ok = 0; m_err = 0;
            end else if (eof_req) begin
                m_st = 2; m_idx = 0;
            end else if (chk_req) begin
                m_ok = (m_crc == 0); m_err = (m_crc != 0);
            end
        end else if (m_st == 1) begin
            bit lsb;
            lsb = m_crc[0];
            m_crc = m_crc >> 1;
            if (lsb) m_crc = m_crc ^ 16'hA001;
            m_left--;
            if (m_left == 0) m_st = 0;
        end else begin
            if (out_ready) begin
                m_idx++;
                if (m_idx == 2) begin m_st = 0; m_idx = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", "model in_ready", in_ready, (m_st == 0) && !clr);
            check("R5", "model out_valid", out_valid, m_st == 2);
            if (m_st == 2)
                check("R5", "model out_data", out_data, m_idx == 0 ? m_crc[7:0] : m_crc[15:8]);
            check("R2", "model crc_out", crc_out, m_crc);
            check("R6", "model crc_ok", crc_ok, m_ok);
            check("R6", "model crc_err", crc_err, m_err);
        end
    end

    always @(posedge clk) begin
        #2;
        out_ready = stall ? ~out_ready : 1'b1;
    end

    // ---------------- stimulus helpers ----------------
    function automatic bit [15:0] ref_byte(bit [15:0] c, bit [7:0] b);
        c = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        return c;
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic send(bit [7:0] b);
        in_valid = 1'b1; in_data = b;
        do @(negedge clk); while (!in_ready);
        tick();
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!in_ready);
        tick();
    endtask

    task automatic send_all(bit [7:0] bytes[$]);
        foreach (bytes[i]) begin send(bytes[i]); wait_idle(); end
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit [7:0] frame[$];
        bit [7:0] got[$];
        int lows;
        bit [15:0] exp_crc;
        frame = '{8'h01, 8'h03, 8'h21, 8'h02, 8'h00, 8'h02};

        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "reset crc", crc_out, 16'hFFFF);
        check("R1", "reset ready", in_ready, 1);
        check("R1", "reset flags", {crc_ok, crc_err, out_valid}, 0);
        tick();

        // R3: low-ready window length
        send(8'h01);
        lows = 0;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            lows++;
        end
        check("R3", "ready-low cycles", lows, 8);
        tick();
        check("R2", "one byte crc", crc_out, ref_byte(16'hFFFF, 8'h01));

        // R4: example frame
        pulse_clr();
        send_all(frame);
        check("R4", "frame crc", crc_out, 16'hF76F);

        // R5: emission with stalls, low byte first
        stall = 1'b1;
        eof_req = 1'b1; tick(); eof_req = 1'b0;
        for (int i = 0; i < 40 && got.size() < 2; i++) begin
            @(negedge clk);
            if (out_valid && out_ready) got.push_back(out_data);
        end
        stall = 1'b0;
        check("R5", "byte count", got.size(), 2);
        if (got.size() == 2) begin
            check("R5", "first byte", got[0], 8'h6F);
            check("R5", "second byte", got[1], 8'hF7);
        end
        check("R5", "crc after emit", crc_out, 16'hF76F);
        tick();

        // R6: good received check bytes
        pulse_clr();
        send_all(frame);
        send_all('{8'h6F, 8'hF7});
        chk_req = 1'b1; tick(); chk_req = 1'b0;
        @(negedge clk);
        check("R6", "good frame ok", crc_ok, 1);
        check("R6", "good frame err", crc_err, 0);
        tick();

        // R6: corrupted check byte
        pulse_clr();
        send_all(frame);
        send_all('{8'h6F, 8'hF6});
        chk_req = 1'b1; tick(); chk_req = 1'b0;
        @(negedge clk);
        check("R6", "bad frame ok", crc_ok, 0);
        check("R6", "bad frame err", crc_err, 1);
        tick();
        send(8'h55);
        @(negedge clk);
        check("R6", "flag cleared by byte", {crc_ok, crc_err}, 0);
        wait_idle();

        // R7: clear in the middle of a byte
        pulse_clr();
        send(8'hA5);
        tick(); tick();
        clr = 1'b1;
        @(negedge clk);
        check("R7", "ready low during clr", in_ready, 0);
        tick(); clr = 1'b0;
        @(negedge clk);
        check("R7", "crc after abort", crc_out, 16'hFFFF);
        check("R7", "ready after abort", in_ready, 1);
        tick();

        // R8: byte beats eof_req in the same cycle
        in_valid = 1'b1; in_data = 8'h3C; eof_req = 1'b1;
        tick();
        in_valid = 1'b0; eof_req = 1'b0;
        @(negedge clk);
        check("R8", "no emission", out_valid, 0);
        check("R8", "byte taken", in_ready, 0);
        wait_idle();
        check("R8", "crc of winner", crc_out, ref_byte(16'hFFFF, 8'h3C));

        // R8: eof_req beats chk_req
        eof_req = 1'b1; chk_req = 1'b1; tick();
        eof_req = 1'b0; chk_req = 1'b0;
        @(negedge clk);
        check("R8", "emission won", out_valid, 1);
        check("R8", "check dropped", {crc_ok, crc_err}, 0);
        // R9: ready low while emitting
        check("R9", "ready during emit", in_ready, 0);
        wait_idle();

        // R2: assorted bytes
        pulse_clr();
        exp_crc = 16'hFFFF;
        for (int i = 0; i < 12; i++) begin
            bit [7:0] b;
            b = 8'(i * 37 + 11) ^ 8'(i << 4);
            send(b); wait_idle();
            exp_crc = ref_byte(exp_crc, b);
        end
        check("R2", "sequence crc", crc_out, exp_crc);

        repeat (3) tick();
        finish_run();
    end
endmodule